// File: doc/BRIEF.md
# Dual-Mode LUT RAM Element

This block is a single 64-bit storage element of the kind found inside a lookup table that can double as a small RAM. The same 64 bits are seen either as 64 one-bit words or as 32 two-bit words. A static mode input chooses between the two views. Writes take effect on the rising clock edge. The read port has its own address and is purely combinational, and it drives two one-bit outputs.

In the two-bit view, bit 1 of word k is held in storage bit 32+k and bit 0 is held in storage bit k. Because of this layout, switching the mode reinterprets the contents without moving any data.

The write address is two bits wider than the read address. Those two upper bits qualify the write when several elements are ganged into a 128-deep or 256-deep memory. Each element compares them with its own bank number, and a depth selector decides how many of the upper bits take part in the comparison. Reset only blocks writes. It never clears the contents, which start at zero.

Top module: `lutram_elem`

## Requirements
- R1: All 64 storage bits read as 0 before any accepted write, and driving rst_n low never changes stored contents.
- R2: With wide_mode=0, a write stores wr_data[0] into storage bit wr_addr[5:0] at the rising edge, and wr_data[1] is ignored.
- R3: With wide_mode=0, rd_hi equals storage bit rd_addr[5:0] and rd_lo is 0.
- R4: With wide_mode=1, a write stores wr_data[1] into storage bit 32+wr_addr[4:0] and wr_data[0] into storage bit wr_addr[4:0], and wr_addr[5] is ignored.
- R5: With wide_mode=1, rd_hi equals storage bit 32+rd_addr[4:0], rd_lo equals storage bit rd_addr[4:0], and rd_addr[5] is ignored.
- R6: Bank qualification works as follows. With depth_sel=0, wr_addr[7:6] is ignored. With depth_sel=1, a write needs wr_addr[6]==bank_sel[0]. With depth_sel=2 or 3, a write needs wr_addr[7:6]==bank_sel.
- R7: With wr_en=0, no storage bit changes.
- R8: With rst_n=0, writes are blocked and the contents are kept.
- R9: The read is asynchronous. When a write targets the address being read, the output shows the old value before the edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Active-low reset; blocks writes only |
| wide_mode | input | 1 | 0: 64x1 view, 1: 32x2 view (static) |
| depth_sel | input | 2 | 0: single element, 1: 128 deep, 2/3: 256 deep |
| bank_sel | input | 2 | This element's bank number within a ganged memory |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Write address; bits 7:6 select the bank |
| wr_data | input | 2 | Write data |
| rd_addr | input | 6 | Read address |
| rd_hi | output | 1 | Read data, upper output |
| rd_lo | output | 1 | Read data, lower output (0 in 64x1 view) |

## Verification
A wrong write-enable decode corrupts a storage bit silently. The damage only appears when that exact address is later read, so the bench reads back every address after each fill pattern. Because the read is combinational, a bad bank match or a bad data-lane pick shows at the outputs in the cycle right after the edge that made it. A mix-up between the two halves in the 32x2 view is exposed when the 64x1 view is read after a wide-mode fill.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

  typedef enum logic [1:0] {
    DEPTH_SOLO  = 2'd0,
    DEPTH_PAIR  = 2'd1,
    DEPTH_QUAD  = 2'd2,
    DEPTH_QUADX = 2'd3
  } depth_e;

  localparam int BANK_W = 2;

  // Does the upper write-address slice select this element's bank?
  function automatic logic bank_hit(input logic [1:0] depth,
                                    input logic [BANK_W-1:0] wa_hi,
                                    input logic [BANK_W-1:0] bank);
    logic hit;
    case (depth)
      DEPTH_SOLO: hit = 1'b1;
      DEPTH_PAIR: hit = (wa_hi[0] == bank[0]);
      default:    hit = (wa_hi == bank);
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/lutram_wr_decode.sv
module lutram_wr_decode
  import lutram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wide_mode,
  input  logic [1:0]               depth_sel,
  input  logic [BANK_W-1:0]        bank_sel,
  input  logic [AW+BANK_W-1:0]     wr_addr,
  input  logic [1:0]               wr_data,
  output logic                     wr_go,
  output logic [(1<<AW)-1:0]       bit_we,
  output logic [(1<<AW)-1:0]       bit_wd
);
  localparam int DEPTH = 1 << AW;

  // Does storage bit idx belong to the addressed word?
  function automatic logic slot_hit(input logic wide, input logic [AW-1:0] wa,
                                    input logic [AW-1:0] idx);
    if (wide) return idx[AW-2:0] == wa[AW-2:0];
    else      return idx == wa;
  endfunction

  // Which data lane feeds storage bit idx
  function automatic logic lane_pick(input logic wide, input logic [1:0] d,
                                     input logic [AW-1:0] idx);
    if (wide && idx[AW-1]) return d[1];
    else                   return d[0];
  endfunction

  logic bank_ok;
  assign bank_ok = bank_hit(depth_sel, wr_addr[AW+BANK_W-1:AW], bank_sel);
  assign wr_go   = rst_n & wr_en & bank_ok;

  for (genvar i = 0; i < DEPTH; i++) begin : g_bit
    localparam logic [AW-1:0] IDX = AW'(i);
    assign bit_we[i] = wr_go & slot_hit(wide_mode, wr_addr[AW-1:0], IDX);
    assign bit_wd[i] = lane_pick(wide_mode, wr_data, IDX);
  end

  assert_narrow_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !wide_mode) |-> $onehot(bit_we));

  assert_wide_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wide_mode) |-> ($countones(bit_we) == 2));

  assert_idle_no_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (bit_we == '0));

  assert_bank_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we != '0) |-> (depth_sel == DEPTH_SOLO ||
      (depth_sel == DEPTH_PAIR && wr_addr[AW] == bank_sel[0]) ||
      (wr_addr[AW+BANK_W-1:AW] == bank_sel)));

endmodule

// File: rtl/lutram_store.sv
module lutram_store #(
  parameter int AW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [(1<<AW)-1:0]   bit_we,
  input  logic [(1<<AW)-1:0]   bit_wd,
  output logic [(1<<AW)-1:0]   mem_q
);
  localparam int DEPTH = 1 << AW;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic cell_q = 1'b0;  // powers up clear; reset never touches it
    always_ff @(posedge clk) begin
      if (bit_we[i]) cell_q <= bit_wd[i];
    end
    assign mem_q[i] = cell_q;

    assert_cell_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_we[i] |=> (mem_q[i] == $past(mem_q[i])));
    assert_cell_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_we[i] |=> (mem_q[i] == $past(bit_wd[i])));
  end

endmodule

// File: rtl/lutram_rd_mux.sv
module lutram_rd_mux #(
  parameter int AW = 6
) (
  input  logic                 wide_mode,
  input  logic [AW-1:0]        rd_addr,
  input  logic [(1<<AW)-1:0]   mem_q,
  output logic                 rd_hi,
  output logic                 rd_lo
);
  // Storage index feeding the upper output
  function automatic logic [AW-1:0] hi_index(input logic wide, input logic [AW-1:0] a);
    if (wide) return {1'b1, a[AW-2:0]};
    else      return a;
  endfunction

  // Storage index feeding the lower output in the wide view
  function automatic logic [AW-1:0] lo_index(input logic [AW-1:0] a);
    return {1'b0, a[AW-2:0]};
  endfunction

  assign rd_hi = mem_q[hi_index(wide_mode, rd_addr)];
  assign rd_lo = wide_mode & mem_q[lo_index(rd_addr)];

endmodule

// File: rtl/lutram_elem.sv
module lutram_elem
  import lutram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wide_mode,
  input  logic [1:0]           depth_sel,
  input  logic [1:0]           bank_sel,
  input  logic                 wr_en,
  input  logic [AW+1:0]        wr_addr,
  input  logic [1:0]           wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic                 rd_hi,
  output logic                 rd_lo
);
  localparam int DEPTH = 1 << AW;

  logic             wr_go;
  logic [DEPTH-1:0] bit_we;
  logic [DEPTH-1:0] bit_wd;
  logic [DEPTH-1:0] mem_q;

  lutram_wr_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wide_mode(wide_mode),
    .depth_sel(depth_sel), .bank_sel(bank_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_go(wr_go), .bit_we(bit_we), .bit_wd(bit_wd)
  );

  lutram_store #(.AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .bit_we(bit_we), .bit_wd(bit_wd), .mem_q(mem_q)
  );

  lutram_rd_mux #(.AW(AW)) u_rd (
    .wide_mode(wide_mode), .rd_addr(rd_addr), .mem_q(mem_q),
    .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  assert_narrow_lo_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode |-> (rd_lo == 1'b0));

  assert_rd_after_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !wide_mode && rd_addr == wr_addr[AW-1:0]) |=>
      (!$stable(rd_addr) || wide_mode || rd_hi == $past(wr_data[0])));

  assert_wide_rd_after_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wide_mode && rd_addr[AW-2:0] == wr_addr[AW-2:0]) |=>
      (!$stable(rd_addr) || !wide_mode || {rd_hi, rd_lo} == $past(wr_data)));

endmodule

// File: tb/lutram_elem_tb_top.sv
module lutram_elem_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 1'b0;
  logic [1:0] depth_sel = 2'd0;
  logic [1:0] bank_sel = 2'd0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [1:0] wr_data = '0;
  logic [5:0] rd_addr = '0;
  logic rd_hi, rd_lo;

  always #5 clk = ~clk;

  lutram_elem dut_i (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .depth_sel(depth_sel),
    .bank_sel(bank_sel), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  typedef struct {
    logic  hi;
    logic  lo;
    int    addr;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  logic model [64];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 0;

  function automatic logic bank_ok(logic [1:0] dsel, logic [1:0] hi, logic [1:0] bk);
    if (dsel == 2'd0) return 1'b1;
    if (dsel == 2'd1) return hi[0] == bk[0];
    return hi == bk;
  endfunction

  function automatic void check(logic [1:0] act, logic [1:0] expv, int addr, string tag);
    n_checks++;
    if (act !== expv) begin
      n_errors++;
      $display("FAIL %s addr=%0d actual=%b expected=%b", tag, addr, act, expv);
    end
  endfunction

  function automatic exp_t predict(logic [5:0] a, string tag);
    exp_t e;
    if (wide_mode) begin
      e.hi = model[32 + int'(a[4:0])];
      e.lo = model[int'(a[4:0])];
    end else begin
      e.hi = model[int'(a)];
      e.lo = 1'b0;
    end
    e.addr = int'(a);
    e.tag = tag;
    return e;
  endfunction

  function automatic void model_write(logic [7:0] wa, logic [1:0] d, logic we);
    if (!rst_n || !we || !bank_ok(depth_sel, wa[7:6], bank_sel)) return;
    if (wide_mode) begin
      model[32 + int'(wa[4:0])] = d[1];
      model[int'(wa[4:0])] = d[0];
    end else begin
      model[int'(wa[5:0])] = d[0];
    end
  endfunction

  task automatic drive_write(logic [7:0] wa, logic [1:0] d, logic we = 1'b1);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = d;
    model_write(wa, d, we);
  endtask

  task automatic read_push(logic [5:0] a, string tag);
    @(negedge clk);
    wr_en = 1'b0; rd_addr = a;
    #2;
    exp_q.push_back(predict(a, tag));
  endtask

  // Monitor: compare combinational outputs shortly after each edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check({rd_hi, rd_lo}, {e.hi, e.lo}, e.addr, e.tag);
      end
    end
  end

  function automatic logic pat(int i, int s);
    return logic'(((i * 37 + s * 11 + 5) >> 2) & 1);
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 1'b0;
    // R1: power-up contents are zero
    for (int a = 0; a < 64; a += 9) read_push(6'(a), "R1");
    // R8: writes blocked while rst_n is low
    drive_write(8'd5, 2'b11);
    drive_write(8'd40, 2'b01);
    read_push(6'd5, "R8");
    read_push(6'd40, "R8");
    @(negedge clk); rst_n = 1'b1;

    // R2/R3: narrow fill, lane 1 carries the inverse (must be ignored)
    for (int i = 0; i < 64; i++) drive_write(8'(i), {~pat(i, 1), pat(i, 1)});
    for (int i = 0; i < 64; i++) read_push(6'(i), "R3");

    // R7: disabled writes leave contents alone
    drive_write(8'd10, {1'b0, ~model[10]}, 1'b0);
    drive_write(8'd63, {1'b0, ~model[63]}, 1'b0);
    read_push(6'd10, "R7");
    read_push(6'd63, "R7");

    // R8/R1: reset mid-run blocks writes and keeps contents
    @(negedge clk); rst_n = 1'b0;
    drive_write(8'd20, {1'b0, ~model[20]});
    read_push(6'd20, "R8");
    read_push(6'd21, "R1");
    @(negedge clk); rst_n = 1'b1;

    // R6: bank qualification
    depth_sel = 2'd1; bank_sel = 2'd1;
    drive_write({2'b00, 6'd3}, {1'b0, ~model[3]});
    read_push(6'd3, "R6");
    drive_write({2'b10, 6'd3}, {1'b0, ~model[3]});
    read_push(6'd3, "R6");
    drive_write({2'b01, 6'd4}, {1'b0, ~model[4]});
    read_push(6'd4, "R6");
    depth_sel = 2'd2; bank_sel = 2'd2;
    drive_write({2'b11, 6'd7}, {1'b0, ~model[7]});
    drive_write({2'b00, 6'd7}, {1'b0, ~model[7]});
    read_push(6'd7, "R6");
    drive_write({2'b10, 6'd7}, {1'b0, ~model[7]});
    read_push(6'd7, "R6");
    depth_sel = 2'd3; bank_sel = 2'd3;
    drive_write({2'b01, 6'd8}, {1'b0, ~model[8]});
    read_push(6'd8, "R6");
    drive_write({2'b11, 6'd8}, {1'b0, ~model[8]});
    read_push(6'd8, "R6");
    depth_sel = 2'd0; bank_sel = 2'd2;
    drive_write({2'b01, 6'd9}, {1'b0, ~model[9]});
    read_push(6'd9, "R6");

    // R4/R5: wide fill with wr_addr[5] toggled, read with rd_addr[5] toggled
    @(negedge clk); wide_mode = 1'b1;
    for (int i = 0; i < 32; i++)
      drive_write({2'b00, 1'(i & 1), 5'(i)}, {pat(i, 2), pat(i, 3)});
    for (int i = 0; i < 32; i++) read_push({1'(~i & 1), 5'(i)}, "R5");

    // R4: narrow view of the wide fill shows the half layout
    @(negedge clk); wide_mode = 1'b0;
    for (int i = 0; i < 64; i++) read_push(6'(i), "R4");

    // R9: read-during-write, old value before the edge, new after
    for (int k = 0; k < 3; k++) begin
      logic [5:0] a;
      logic nv;
      a = 6'(k * 21 + 2);
      nv = ~model[int'(a)];
      @(negedge clk);
      rd_addr = a; wr_addr = {2'b00, a}; wr_data = {1'b0, nv}; wr_en = 1'b1;
      #2;
      check({rd_hi, rd_lo}, {model[int'(a)], 1'b0}, int'(a), "R9");
      model_write({2'b00, a}, {1'b0, nv}, 1'b1);
      exp_q.push_back(predict(a, "R9"));
    end
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule